// File: doc/BRIEF.md
# Double-Buffered Converter Input Register

This block holds the input word of a digital-to-analog converter in two ranks. A host writes a word onto the parallel bus into the first rank. It does this by pulling both an active-low chip select and an active-low first-rank strobe low. While either of those lines is high, the first rank keeps its word. A separate active-high load line copies the first-rank word into the second rank, and the second rank drives the converter code.

The load line is not qualified by chip select. Several instances that share one load line therefore change their outputs on the same clock. Both ranks are modelled as level-sensitive enables that are sampled on every rising edge of the system clock. When both ranks are open at one edge, the bus word reaches the output at that same edge.

The usual board strap options need no extra logic:
- **Second rank transparent:** tie the load line high.
- **Both ranks transparent:** also tie chip select and the strobe low.
- **Edge-triggered master-slave mode:** tie chip select to the load line and tie the strobe low.

Top module: `dac_dual_rank_reg`

## Requirements
- R1: A synchronous active-high reset clears both ranks to zero and deasserts `code_valid`. After reset, a second-rank load that is not preceded by any write gives `code_out` = 0.
- R2: At a clock edge where `cs_n` and `wr1_n` are both low, the first rank takes the value on `bus_data`.
- R3: At a clock edge where `cs_n` or `wr1_n` is high, the first rank keeps its word, whatever is on `bus_data`.
- R4: At a clock edge where `load2` is low, `code_out` does not change, whatever the first-rank controls and the bus do.
- R5: At a clock edge where `load2` is high, the second rank takes the first-rank word, including while `cs_n` is high.
- R6: When `cs_n` and `wr1_n` are low and `load2` is high at the same edge, `code_out` equals the `bus_data` value sampled at that edge.
- R7: With `cs_n` tied to `load2` and `wr1_n` held low, `code_out` after a rising edge of the pair equals the bus word present in the last cycle before the rise. Bus changes while the pair is high do not reach `code_out`.
- R8: While `load2` is held high and the first rank is closed, `code_out` equals the first-rank word from the edge after each write on.
- R9: `code_valid` rises at the first edge after reset where `load2` is high, and it stays high until the next reset.
- R10: The coding is straight binary. `code_out` reproduces the stored word bit for bit, with no inversion or offset; for example 16'h7FFF and 16'h8000 appear unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 16 | Parallel word from the host bus |
| cs_n | input | 1 | Chip select, active low |
| wr1_n | input | 1 | First-rank load strobe, active low |
| load2 | input | 1 | Second-rank load, active high, not gated by chip select |
| code_out | output | 16 | Registered converter code from the second rank |
| code_valid | output | 1 | High once a second-rank load has occurred since reset |

## Verification
The first rank cannot be seen directly. A wrong first-rank word stays hidden until the next edge with `load2` high, and it then shows on `code_out` one cycle later. The bench therefore follows every hold scenario with a load.

A second rank that leaks is different. It shows up at the first edge where `load2` is low and the bus or controls move, as a change on `code_out`, and the in-module stability check reports it in that cycle.

A late or missing `code_valid` shows one cycle after the first load.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  parameter int DEFAULT_W = 16;

  typedef struct packed {
    logic open1;
    logic open2;
  } gate_t;

  function automatic gate_t decode_gates(input logic cs_n, input logic wr1_n,
                                         input logic load2);
    gate_t g;
    g.open1 = ~cs_n & ~wr1_n;
    g.open2 = load2;
    return g;
  endfunction
endpackage

// File: rtl/dacreg_rank1.sv
module dacreg_rank1 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         open_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] next_o
);
  logic [W-1:0] word_q;

  assign next_o = open_i ? d_i : word_q;
  assign q_o    = word_q;

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= next_o;
  end

  // R2
  rank1_capture_chk: assert property (@(posedge clk) disable iff (rst)
    open_i |=> (word_q == $past(d_i)));

  // R3
  rank1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !open_i |=> $stable(word_q));
endmodule

// File: rtl/dacreg_rank2.sv
module dacreg_rank2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         open_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         valid_o
);
  logic [W-1:0] word_q;
  logic         valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else if (open_i) begin
      word_q  <= d_i;
      valid_q <= 1'b1;
    end
  end

  assign q_o     = word_q;
  assign valid_o = valid_q;

  // R9
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q);

  // R9
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(open_i));
endmodule

// File: rtl/dac_dual_rank_reg.sv
module dac_dual_rank_reg #(
  parameter int WIDTH = dacreg_pkg::DEFAULT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] bus_data,
  input  logic             cs_n,
  input  logic             wr1_n,
  input  logic             load2,
  output logic [WIDTH-1:0] code_out,
  output logic             code_valid
);
  import dacreg_pkg::*;

  localparam int MSB = WIDTH - 1;

  gate_t        gates;
  logic [MSB:0] r1_word;
  logic [MSB:0] r1_next;

  assign gates = decode_gates(cs_n, wr1_n, load2);

  dacreg_rank1 #(.W(WIDTH)) u_rank1 (
    .clk    (clk),
    .rst    (rst),
    .open_i (gates.open1),
    .d_i    (bus_data),
    .q_o    (r1_word),
    .next_o (r1_next)
  );

  dacreg_rank2 #(.W(WIDTH)) u_rank2 (
    .clk     (clk),
    .rst     (rst),
    .open_i  (gates.open2),
    .d_i     (r1_next),
    .q_o     (code_out),
    .valid_o (code_valid)
  );

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load2 |=> $stable(code_out));

  // R6
  flow_through_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr1_n && load2) |=> (code_out == $past(bus_data)));

  // R5
  load_from_rank1_chk: assert property (@(posedge clk) disable iff (rst)
    (load2 && cs_n) |=> (code_out == $past(r1_word)));
endmodule

// File: tb/tb_dac_dual_rank_reg.sv
module tb_dac_dual_rank_reg;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] bus_data;
  logic         cs_n, wr1_n, load2;
  logic [W-1:0] code_out;
  logic         code_valid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dac_dual_rank_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .bus_data(bus_data), .cs_n(cs_n),
    .wr1_n(wr1_n), .load2(load2), .code_out(code_out), .code_valid(code_valid)
  );

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply values just after the falling edge, then let one rising edge pass
  task automatic step(input logic [W-1:0] d, input logic c, input logic w,
                      input logic l);
    bus_data = d; cs_n = c; wr1_n = w; load2 = l;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(16'hFFFF, 1'b1, 1'b1, 1'b0);
    step(16'hFFFF, 1'b1, 1'b1, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 out", code_out, 16'h0000);
    check("R1 valid", {15'b0, code_valid}, 16'h0000);
    step(16'hABCD, 1'b1, 1'b1, 1'b1);
    check("R1 rank1 cleared", code_out, 16'h0000);
    check("R9 valid after load", {15'b0, code_valid}, 16'h0001);
  endtask

  task automatic t_write_and_hold();
    do_reset();
    step(16'h1234, 1'b0, 1'b0, 1'b0);
    check("R4 out held during write", code_out, 16'h0000);
    check("R9 valid not yet", {15'b0, code_valid}, 16'h0000);
    step(16'h5555, 1'b1, 1'b0, 1'b0);
    step(16'h6666, 1'b0, 1'b1, 1'b0);
    check("R4 out held during bus churn", code_out, 16'h0000);
    step(16'h7777, 1'b1, 1'b1, 1'b1);
    check("R2 R3 R5 loaded word", code_out, 16'h1234);
    step(16'h9999, 1'b1, 1'b1, 1'b0);
    check("R9 valid sticky", {15'b0, code_valid}, 16'h0001);
  endtask

  task automatic t_flow_through();
    do_reset();
    step(16'h7FFF, 1'b0, 1'b0, 1'b1);
    check("R6 R10 same-edge 7FFF", code_out, 16'h7FFF);
    step(16'h8000, 1'b0, 1'b0, 1'b1);
    check("R6 R10 same-edge 8000", code_out, 16'h8000);
  endtask

  task automatic t_master_slave();
    do_reset();
    step(16'h0F0F, 1'b0, 1'b0, 1'b0);
    step(16'hA5A5, 1'b0, 1'b0, 1'b0);
    step(16'hC3C3, 1'b1, 1'b0, 1'b1);
    check("R7 data before rise", code_out, 16'hA5A5);
    step(16'h3C3C, 1'b1, 1'b0, 1'b1);
    check("R7 bus ignored while high", code_out, 16'hA5A5);
    step(16'h1111, 1'b0, 1'b0, 1'b0);
    check("R7 R4 no change on fall", code_out, 16'hA5A5);
    step(16'h2222, 1'b1, 1'b0, 1'b1);
    check("R7 second rise", code_out, 16'h1111);
  endtask

  task automatic t_load_high();
    do_reset();
    step(16'h0000, 1'b1, 1'b1, 1'b1);
    step(16'hBEEF, 1'b0, 1'b0, 1'b1);
    step(16'hDEAD, 1'b1, 1'b1, 1'b1);
    check("R8 follows rank1", code_out, 16'hBEEF);
    step(16'h4242, 1'b0, 1'b1, 1'b1);
    check("R8 R3 strobe high holds", code_out, 16'hBEEF);
  endtask

  initial begin
    rst = 1'b1; bus_data = '0; cs_n = 1'b1; wr1_n = 1'b1; load2 = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_and_hold();
    t_flow_through();
    t_master_slave();
    t_load_high();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule